// File: doc/BRIEF.md
# Gateway Condition Table with Payload Inhibit

This block is a small lookup stage that sits in front of the result path of a match table. On every cycle it compares a search key against five ternary condition rows. The lowest-numbered valid row that agrees with the key wins. When no condition row agrees, a sixth, unconditional miss row wins. Each row holds four things: an inhibit flag, a next-table identifier, a wide payload word and a flag that chooses how an all-zero field group is read. A winning row with inhibit set takes over from the linked match table. It forces the hit pathway, puts its own payload on the result bus and supplies the next-table value. A winning row without inhibit lets the linked table's hit flag, result bus and next table pass through unchanged.

After the result bus is chosen, a field group is shifted out of it. The group holds an action code, a meter enable and a meter type. In per-row format mode, each row brings its own shift count, so several rows can share one packed payload layout and each reach its own slice. In shared format mode, every row reads the group from bit 0. When an inhibiting row yields an all-zero group, the block flags it as a no-op or as the default action, according to that row's flag. Rows are loaded one at a time through a configuration write port.

Top module: `gwt_cond_table`

## Requirements
- R1: After reset every output is zero. All condition rows are invalid and the miss row does not inhibit, so lookups pass through with winning row index 5.
- R2: Condition row i agrees with the key when its valid bit is set and (key AND mask) equals (value AND mask). An invalid row never agrees, whatever its mask.
- R3: `out_row` reports the winner: the lowest agreeing condition row index 0 to 4, or 5 (the miss row) when none agrees.
- R4: When the winning row has inhibit set, `out_hit` is 1, `out_result` is that row's payload and `out_next` is that row's next-table value, even when `mt_hit` is 0.
- R5: When the winning row has inhibit clear, `out_hit`, `out_result` and `out_next` equal `mt_hit`, `mt_result` and `mt_next`.
- R6: With `fmt_per_row` = 1, the group is taken as (result bus >> winning row's shift) bits 5:0. The action is bits 1:0, the meter enable is bit 2 and the meter type is bits 5:3.
- R7: With `fmt_per_row` = 0, the same group is taken at shift 0 for every row, whatever the rows' shift counts are.
- R8: When the winner inhibits and its group is all zero, `out_noop` is 1 if the row's default flag is 0, and `out_dflt` is 1 if that flag is 1. In every other case both are 0.
- R9: Outputs follow the inputs sampled at a rising edge, one cycle later. A row written at an edge is used from the next edge on. A lookup at the same edge as the write still sees the old row.
- R10: A write with `cfg_row` greater than 5 changes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 3 | Row to write (0-4 condition, 5 miss) |
| cfg_valid | input | 1 | Row valid bit to write |
| cfg_mask | input | KEY_W | Ternary mask to write |
| cfg_value | input | KEY_W | Compare value to write |
| cfg_inhibit | input | 1 | Inhibit flag to write |
| cfg_next | input | NT_W | Next-table value to write |
| cfg_payload | input | PAYLOAD_W | Payload word to write |
| cfg_shift | input | SH_W | Per-row field shift to write |
| cfg_dflt | input | 1 | Zero-group-means-default flag to write |
| fmt_per_row | input | 1 | 1: per-row shift, 0: shared shift 0 |
| key | input | KEY_W | Search key |
| mt_hit | input | 1 | Linked table hit flag |
| mt_result | input | PAYLOAD_W | Linked table result bus |
| mt_next | input | NT_W | Linked table next-table value |
| out_hit | output | 1 | Hit pathway select |
| out_result | output | PAYLOAD_W | Result bus to hit pathway |
| out_next | output | NT_W | Final next-table value |
| out_row | output | 3 | Winning row index |
| out_inhibit | output | 1 | Winning row inhibited |
| out_action | output | ACT_W | Extracted action code |
| out_meter_en | output | 1 | Extracted meter enable |
| out_meter_type | output | MTYPE_W | Extracted meter type |
| out_noop | output | 1 | Inhibit with zero group read as no-op |
| out_dflt | output | 1 | Inhibit with zero group read as default action |

## Verification
The pass-through assertions assume that `mt_hit` and `mt_result` hold defined values through each cycle. The bench meets this by driving every input on the falling edge and never leaving one undriven. The no-op and default assertions assume nothing about the payloads, so the stimulus loads zero groups, non-zero groups and slices at the bus edge into rows that can win. Keys are swept over the whole 8-bit space in both format modes. Row loads are placed both before a lookup and at the same edge as one, so the one-cycle delay before a write takes effect is exercised.

// File: rtl/gwt_pkg.sv
package gwt_pkg;
    localparam int GW_COND_ROWS = 5;
    localparam int GW_PAYLOAD_W = 83;
    localparam int GW_ACT_W     = 2;
    localparam int GW_MTYPE_W   = 3;

    typedef enum logic [0:0] {
        FMT_SHARED  = 1'b0,
        FMT_PER_ROW = 1'b1
    } fmt_mode_e;
endpackage

// File: rtl/gwt_row_match.sv
module gwt_row_match #(
    parameter int KEY_W = 16
) (
    input  logic [KEY_W-1:0] key_i,
    input  logic             valid_i,
    input  logic [KEY_W-1:0] mask_i,
    input  logic [KEY_W-1:0] value_i,
    output logic             hit_o
);
    logic [KEY_W-1:0] diff;

    always_comb begin
        diff  = (key_i ^ value_i) & mask_i;
        hit_o = valid_i && (diff == '0);
    end
endmodule

// File: rtl/gwt_prio_pick.sv
module gwt_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |req_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        grant_o = any_o ? (N'(1) << idx_o) : '0;
    end

    // R3: only one row may win, and the winner must be a requesting row
    always_comb begin
        a_r3_single_grant : assert ($onehot0(grant_o));
        a_r3_grant_in_req : assert (!any_o || ((grant_o & req_i) != '0));
    end
endmodule

// File: rtl/gwt_field_extract.sv
module gwt_field_extract #(
    parameter int PAYLOAD_W = 83,
    parameter int SH_W      = 7,
    parameter int ACT_W     = 2,
    parameter int MTYPE_W   = 3
) (
    input  logic [PAYLOAD_W-1:0] bus_i,
    input  logic [SH_W-1:0]      shift_i,
    output logic [ACT_W-1:0]     action_o,
    output logic                 meter_en_o,
    output logic [MTYPE_W-1:0]   meter_type_o,
    output logic                 zero_o
);
    localparam int GRP_W = ACT_W + 1 + MTYPE_W;

    logic [PAYLOAD_W-1:0] shifted;
    logic [GRP_W-1:0]     grp;

    always_comb begin
        shifted      = bus_i >> shift_i;
        grp          = shifted[GRP_W-1:0];
        action_o     = grp[ACT_W-1:0];
        meter_en_o   = grp[ACT_W];
        meter_type_o = grp[GRP_W-1:ACT_W+1];
        zero_o       = (grp == '0);
    end
endmodule

// File: rtl/gwt_cond_table.sv
module gwt_cond_table
    import gwt_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int NT_W      = 8,
    parameter int COND_ROWS = GW_COND_ROWS,
    parameter int PAYLOAD_W = GW_PAYLOAD_W,
    parameter int ACT_W     = GW_ACT_W,
    parameter int MTYPE_W   = GW_MTYPE_W,
    localparam int TOT      = COND_ROWS + 1,
    localparam int IDX_W    = $clog2(TOT),
    localparam int SH_W     = $clog2(PAYLOAD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_row,
    input  logic                 cfg_valid,
    input  logic [KEY_W-1:0]     cfg_mask,
    input  logic [KEY_W-1:0]     cfg_value,
    input  logic                 cfg_inhibit,
    input  logic [NT_W-1:0]      cfg_next,
    input  logic [PAYLOAD_W-1:0] cfg_payload,
    input  logic [SH_W-1:0]      cfg_shift,
    input  logic                 cfg_dflt,
    input  logic                 fmt_per_row,
    input  logic [KEY_W-1:0]     key,
    input  logic                 mt_hit,
    input  logic [PAYLOAD_W-1:0] mt_result,
    input  logic [NT_W-1:0]      mt_next,
    output logic                 out_hit,
    output logic [PAYLOAD_W-1:0] out_result,
    output logic [NT_W-1:0]      out_next,
    output logic [IDX_W-1:0]     out_row,
    output logic                 out_inhibit,
    output logic [ACT_W-1:0]     out_action,
    output logic                 out_meter_en,
    output logic [MTYPE_W-1:0]   out_meter_type,
    output logic                 out_noop,
    output logic                 out_dflt
);
    typedef struct packed {
        logic                 valid;
        logic [KEY_W-1:0]     mask;
        logic [KEY_W-1:0]     value;
        logic                 inhibit;
        logic [NT_W-1:0]      nxt;
        logic [PAYLOAD_W-1:0] payload;
        logic [SH_W-1:0]      shift;
        logic                 dflt;
    } row_t;

    typedef struct packed {
        logic                 hit;
        logic [PAYLOAD_W-1:0] result;
        logic [NT_W-1:0]      nxt;
        logic [IDX_W-1:0]     row;
        logic                 inhibit;
        logic [ACT_W-1:0]     action;
        logic                 meter_en;
        logic [MTYPE_W-1:0]   meter_type;
        logic                 noop;
        logic                 dflt;
    } res_t;

    typedef struct packed {
        row_t [TOT-1:0] tbl;
        res_t           res;
    } state_t;

    state_t st_d, st_q;

    // ---------------- condition row compare ----------------
    logic [COND_ROWS-1:0] row_hit;

    for (genvar g = 0; g < COND_ROWS; g++) begin : g_row
        gwt_row_match #(.KEY_W(KEY_W)) u_match (
            .key_i   (key),
            .valid_i (st_q.tbl[g].valid),
            .mask_i  (st_q.tbl[g].mask),
            .value_i (st_q.tbl[g].value),
            .hit_o   (row_hit[g])
        );
    end

    logic [COND_ROWS-1:0] grant;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_any;

    gwt_prio_pick #(.N(COND_ROWS), .IDX_W(IDX_W)) u_pick (
        .req_i   (row_hit),
        .grant_o (grant),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    // ---------------- winner select and bus choice ----------------
    logic [IDX_W-1:0]     win_idx;
    row_t                 win_row;
    logic [PAYLOAD_W-1:0] bus_c;
    logic [SH_W-1:0]      shift_c;
    fmt_mode_e            fmt_c;

    always_comb begin
        win_idx = pick_any ? pick_idx : IDX_W'(COND_ROWS);
        win_row = st_q.tbl[COND_ROWS];
        for (int r = 0; r < COND_ROWS; r++) begin
            if (grant[r]) begin
                win_row = st_q.tbl[r];
            end
        end
        fmt_c   = fmt_mode_e'(fmt_per_row);
        bus_c   = win_row.inhibit ? win_row.payload : mt_result;
        shift_c = (fmt_c == FMT_PER_ROW) ? win_row.shift : '0;
    end

    logic [ACT_W-1:0]   ext_action;
    logic               ext_meter_en;
    logic [MTYPE_W-1:0] ext_meter_type;
    logic               ext_zero;

    gwt_field_extract #(
        .PAYLOAD_W (PAYLOAD_W),
        .SH_W      (SH_W),
        .ACT_W     (ACT_W),
        .MTYPE_W   (MTYPE_W)
    ) u_extract (
        .bus_i        (bus_c),
        .shift_i      (shift_c),
        .action_o     (ext_action),
        .meter_en_o   (ext_meter_en),
        .meter_type_o (ext_meter_type),
        .zero_o       (ext_zero)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;

        for (int r = 0; r < TOT; r++) begin
            if (cfg_we && (cfg_row == IDX_W'(r))) begin
                st_d.tbl[r].valid   = cfg_valid;
                st_d.tbl[r].mask    = cfg_mask;
                st_d.tbl[r].value   = cfg_value;
                st_d.tbl[r].inhibit = cfg_inhibit;
                st_d.tbl[r].nxt     = cfg_next;
                st_d.tbl[r].payload = cfg_payload;
                st_d.tbl[r].shift   = cfg_shift;
                st_d.tbl[r].dflt    = cfg_dflt;
            end
        end

        st_d.res.row        = win_idx;
        st_d.res.inhibit    = win_row.inhibit;
        st_d.res.hit        = win_row.inhibit ? 1'b1 : mt_hit;
        st_d.res.result     = bus_c;
        st_d.res.nxt        = win_row.inhibit ? win_row.nxt : mt_next;
        st_d.res.action     = ext_action;
        st_d.res.meter_en   = ext_meter_en;
        st_d.res.meter_type = ext_meter_type;
        st_d.res.noop       = win_row.inhibit && ext_zero && !win_row.dflt;
        st_d.res.dflt       = win_row.inhibit && ext_zero && win_row.dflt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_hit        = st_q.res.hit;
    assign out_result     = st_q.res.result;
    assign out_next       = st_q.res.nxt;
    assign out_row        = st_q.res.row;
    assign out_inhibit    = st_q.res.inhibit;
    assign out_action     = st_q.res.action;
    assign out_meter_en   = st_q.res.meter_en;
    assign out_meter_type = st_q.res.meter_type;
    assign out_noop       = st_q.res.noop;
    assign out_dflt       = st_q.res.dflt;

    // ---------------- assertions ----------------
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    a_r4_inhibit_forces_hit : assert property (@(posedge clk) disable iff (!rst_n)
        out_inhibit |-> out_hit);

    a_r5_pass_hit : assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !out_inhibit) |-> (out_hit == $past(mt_hit)));

    a_r5_pass_result : assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !out_inhibit) |-> (out_result == $past(mt_result)));

    a_r5_pass_next : assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !out_inhibit) |-> (out_next == $past(mt_next)));

    a_r3_row_range : assert property (@(posedge clk) disable iff (!rst_n)
        out_row <= IDX_W'(COND_ROWS));

    a_r8_zero_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
        !(out_noop && out_dflt));

    a_r8_zero_needs_inhibit : assert property (@(posedge clk) disable iff (!rst_n)
        (out_noop || out_dflt) |->
            (out_inhibit && out_action == '0 && !out_meter_en && out_meter_type == '0));
endmodule

// File: tb/gwt_cond_table_tb.sv
module gwt_cond_table_tb_top;
    localparam int KW = 8;
    localparam int NW = 8;
    localparam int PW = 83;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [2:0]    cfg_row;
    logic          cfg_valid;
    logic [KW-1:0] cfg_mask, cfg_value;
    logic          cfg_inhibit;
    logic [NW-1:0] cfg_next;
    logic [PW-1:0] cfg_payload;
    logic [SW-1:0] cfg_shift;
    logic          cfg_dflt;
    logic          fmt_per_row;
    logic [KW-1:0] key;
    logic          mt_hit;
    logic [PW-1:0] mt_result;
    logic [NW-1:0] mt_next;
    logic          out_hit;
    logic [PW-1:0] out_result;
    logic [NW-1:0] out_next;
    logic [2:0]    out_row;
    logic          out_inhibit;
    logic [1:0]    out_action;
    logic          out_meter_en;
    logic [2:0]    out_meter_type;
    logic          out_noop, out_dflt;

    always #2.5 clk = ~clk;

    gwt_cond_table #(.KEY_W(KW), .NT_W(NW)) dut_i (
        .clk, .rst_n, .cfg_we, .cfg_row, .cfg_valid, .cfg_mask, .cfg_value,
        .cfg_inhibit, .cfg_next, .cfg_payload, .cfg_shift, .cfg_dflt,
        .fmt_per_row, .key, .mt_hit, .mt_result, .mt_next,
        .out_hit, .out_result, .out_next, .out_row, .out_inhibit,
        .out_action, .out_meter_en, .out_meter_type, .out_noop, .out_dflt
    );

    int n_chk  = 0;
    int n_fail = 0;

    // shadow of the table, built from what the bench writes
    logic          s_valid [6];
    logic [KW-1:0] s_mask  [6];
    logic [KW-1:0] s_value [6];
    logic          s_inh   [6];
    logic [NW-1:0] s_next  [6];
    logic [PW-1:0] s_pl    [6];
    logic [SW-1:0] s_sh    [6];
    logic          s_dflt  [6];

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] mkpl(input int sh, input logic [5:0] grp, input logic [PW-1:0] bg);
        logic [PW-1:0] m;
        m = PW'(6'h3f) << sh;
        return (bg & ~m) | (PW'(grp) << sh);
    endfunction

    function automatic logic [PW-1:0] res_pat(input logic [KW-1:0] k);
        return PW'({11{k ^ 8'h3C}});
    endfunction

    // expected outputs for the current shadow and inputs
    logic [2:0]    e_row;
    logic          e_inh, e_hit, e_noop, e_dflt;
    logic [PW-1:0] e_res;
    logic [NW-1:0] e_next;
    logic [5:0]    e_grp;

    task automatic predict(input logic [KW-1:0] k, input logic mh, input logic fm);
        logic [PW-1:0] sh;
        e_row = 3'd5;
        for (int i = 4; i >= 0; i--) begin
            // R2: valid and (key & mask) == (value & mask)
            if (s_valid[i] && ((k & s_mask[i]) == (s_value[i] & s_mask[i]))) e_row = 3'(i);
        end
        e_inh  = s_inh[e_row];
        e_hit  = e_inh ? 1'b1 : mh;
        e_res  = e_inh ? s_pl[e_row] : res_pat(k);
        e_next = e_inh ? s_next[e_row] : ~k;
        sh     = e_res >> (fm ? s_sh[e_row] : 7'd0);
        e_grp  = sh[5:0];
        e_noop = e_inh && (e_grp == 6'd0) && !s_dflt[e_row];
        e_dflt = e_inh && (e_grp == 6'd0) && s_dflt[e_row];
    endtask

    task automatic drive_lookup(input logic [KW-1:0] k, input logic mh, input logic fm);
        key         = k;
        mt_hit      = mh;
        mt_result   = res_pat(k);
        mt_next     = ~k;
        fmt_per_row = fm;
    endtask

    task automatic compare(input string ctx, input logic fm);
        chk({ctx, " R3 row"}, 128'(out_row), 128'(e_row));
        chk({ctx, e_inh ? " R4 hit" : " R5 hit"}, 128'(out_hit), 128'(e_hit));
        chk({ctx, e_inh ? " R4 result" : " R5 result"}, 128'(out_result), 128'(e_res));
        chk({ctx, e_inh ? " R4 next" : " R5 next"}, 128'(out_next), 128'(e_next));
        chk({ctx, fm ? " R6 group" : " R7 group"},
            128'({out_meter_type, out_meter_en, out_action}), 128'(e_grp));
        chk({ctx, " R8 noop/dflt"}, 128'({out_noop, out_dflt}), 128'({e_noop, e_dflt}));
    endtask

    task automatic lookup(input logic [KW-1:0] k, input logic mh, input logic fm, input string ctx);
        drive_lookup(k, mh, fm);
        predict(k, mh, fm);
        @(negedge clk);
        compare(ctx, fm);
    endtask

    task automatic put_row(input int r, input logic v, input logic [KW-1:0] m, input logic [KW-1:0] val,
                           input logic inh, input logic [NW-1:0] nx, input logic [PW-1:0] pl,
                           input logic [SW-1:0] sh, input logic df);
        cfg_we = 1'b1; cfg_row = 3'(r); cfg_valid = v; cfg_mask = m; cfg_value = val;
        cfg_inhibit = inh; cfg_next = nx; cfg_payload = pl; cfg_shift = sh; cfg_dflt = df;
    endtask

    task automatic commit_row(input int r);
        if (r < 6) begin
            s_valid[r] = cfg_valid; s_mask[r] = cfg_mask; s_value[r] = cfg_value;
            s_inh[r] = cfg_inhibit; s_next[r] = cfg_next; s_pl[r] = cfg_payload;
            s_sh[r] = cfg_shift; s_dflt[r] = cfg_dflt;
        end
        cfg_we = 1'b0;
    endtask

    task automatic write_row(input int r, input logic v, input logic [KW-1:0] m, input logic [KW-1:0] val,
                             input logic inh, input logic [NW-1:0] nx, input logic [PW-1:0] pl,
                             input logic [SW-1:0] sh, input logic df);
        put_row(r, v, m, val, inh, nx, pl, sh, df);
        @(negedge clk);
        commit_row(r);
    endtask

    task automatic sweep(input logic fm, input string ctx);
        for (int k = 0; k < 256; k++) begin
            lookup(8'(k), k[0] ^ k[3], fm, ctx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            s_valid[i] = 0; s_mask[i] = 0; s_value[i] = 0; s_inh[i] = 0;
            s_next[i] = 0; s_pl[i] = 0; s_sh[i] = 0; s_dflt[i] = 0;
        end
        rst_n = 1'b0;
        cfg_we = 0; cfg_row = 0; cfg_valid = 0; cfg_mask = 0; cfg_value = 0;
        cfg_inhibit = 0; cfg_next = 0; cfg_payload = 0; cfg_shift = 0; cfg_dflt = 0;
        drive_lookup(8'h5A, 1'b1, 1'b1);
        repeat (3) @(negedge clk);

        // R1: reset state of all outputs
        chk("R1 reset outputs",
            128'({out_hit, out_next, out_row, out_inhibit, out_action, out_meter_en,
                  out_meter_type, out_noop, out_dflt}), 128'(0));
        chk("R1 reset result", 128'(out_result), 128'(0));
        rst_n = 1'b1;
        // R1: empty table passes through via miss row
        lookup(8'h5A, 1'b1, 1'b1, "R1 empty table");
        lookup(8'hC3, 1'b0, 1'b1, "R1 empty table");

        write_row(0, 1, 8'hF0, 8'h30, 1, 8'h11, mkpl(0, 6'b101_1_10, PW'({11{8'hA5}})), 7'd0, 0);
        write_row(1, 1, 8'h0F, 8'h05, 1, 8'h22, mkpl(6, 6'b011_0_01, PW'({11{8'h5A}})), 7'd6, 0);
        write_row(2, 0, 8'h00, 8'h00, 1, 8'h33, {PW{1'b1}}, 7'd0, 0);
        write_row(3, 1, 8'hFF, 8'h48, 0, 8'h44, PW'(0), 7'd40, 0);
        write_row(4, 1, 8'h80, 8'h80, 1, 8'h55, mkpl(77, 6'd0, {PW{1'b1}}), 7'd77, 1);
        write_row(5, 0, 8'h00, 8'h00, 0, 8'h66, PW'(0), 7'd3, 0);

        // R2 R3 R4 R5 R6 R8: full key sweep in per-row format
        sweep(1'b1, "ext sweep");
        // R7: shared format ignores row shifts
        sweep(1'b0, "legacy sweep");

        // R9: same-edge write is not seen, next lookup is
        put_row(2, 1, 8'hFF, 8'h99, 1, 8'h33, mkpl(12, 6'h2A, PW'(0)), 7'd12, 0);
        drive_lookup(8'h99, 1'b0, 1'b1);
        predict(8'h99, 1'b0, 1'b1);
        chk("R9 old row expected winner", 128'(e_row), 128'(4));
        @(negedge clk);
        compare("R9 same-edge write", 1'b1);
        commit_row(2);
        lookup(8'h99, 1'b0, 1'b1, "R9 after write");
        chk("R9 new row wins", 128'(out_row), 128'(2));

        // R10: out-of-range rows are dropped
        write_row(6, 1, 8'h00, 8'h00, 1, 8'hEE, {PW{1'b1}}, 7'd0, 1);
        write_row(7, 1, 8'h00, 8'h00, 1, 8'hEF, {PW{1'b1}}, 7'd0, 1);
        for (int k = 0; k < 256; k += 7) lookup(8'(k), 1'b0, 1'b1, "R10 after bad row write");

        // R8: miss row inhibits with zero payload -> no-op
        write_row(5, 0, 8'h00, 8'h00, 1, 8'h77, PW'(0), 7'd0, 0);
        sweep(1'b1, "R8 miss noop sweep");
        lookup(8'h01, 1'b0, 1'b1, "R8 miss noop");
        chk("R8 miss noop flag", 128'(out_noop), 128'(1));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule